// File: doc/BRIEF.md
# SDRAM Command-Mode Sequencer

This block drives the control pins of up to two SDRAM devices from a single command word that software writes. Each command word carries an operation code, one select bit per device, a repeat count for auto-refresh and a value for the device mode register. The engine emits the matching pin command to the selected devices for one clock and raises `busy`. It holds `busy` for the programmed recovery time, counted in SDRAM clocks, and then drops it. Power-up bring-up is therefore a software loop: write a command, poll `busy`, write the next. The usual bring-up order is clock enable, a wait of at least 200 µs, precharge-all, several auto-refreshes, mode-register load, and finally normal mode.

A second register holds seven 4-bit recovery times. Each field stores its delay minus one. A third register holds the reload value of a refresh interval counter. This counter runs only in normal mode and queues one auto-refresh each time it expires. The queued refresh goes to the devices named by the last normal-mode command. All three registers share one write port that is selected by `wr_sel`. There is no streaming data at the block's edge, so every pin is plain control or status.

Top module: `sdram_cmd_seq`

## Requirements
- R1: In reset and in the first cycle after it, `busy`=0, `sd_cke`=00, `sd_cs_n`=11, {`sd_ras_n`,`sd_cas_n`,`sd_we_n`}=111 and `sd_addr`=0.
- R2: With `wr_sel`=0 the write is a command word. The operation code sits in bits [2:0]. Bit 4 selects device 0 (`sd_cs_n[0]`, `sd_cke[0]`) and bit 3 selects device 1. A pin command drives chip select low only for the selected devices. With no device selected, both chip selects stay high while the command still runs its busy time.
- R3: Code 1 (clock enable) sets `sd_cke` of the selected devices and sends no command. `busy` lasts 1 cycle.
- R4: Code 2 (precharge all) sends RAS#=0, CAS#=1, WE#=0 with address bit 10 high for one cycle. `busy` lasts tRP field + 1 cycles.
- R5: Code 3 (auto-refresh) with count N in bits [8:5] sends N+1 refresh pulses (RAS#=0, CAS#=0, WE#=1), spaced tRC field + 1 cycles apart. `busy` lasts (N+1)·(tRC+1) cycles.
- R6: Code 4 (mode load) sends RAS#=CAS#=WE#=0 with `sd_addr` equal to command bits [21:9]. Inside that value, burst length is at bit 0 and CAS latency at bits [6:4]. `busy` lasts tMRD field + 1 cycles.
- R7: Code 5 (self-refresh) sends a refresh pulse to the selected devices and lowers their `sd_cke` in the same cycle. `busy` lasts tRAS field + 1 cycles. A later code 0 to a device in self-refresh holds `busy` for tXSR field + 1 cycles.
- R8: Code 6 (power-down) clears `sd_cke` of the selected devices and sends no command. `busy` lasts 1 cycle.
- R9: Code 0 (normal) sets `sd_cke` of the selected devices, records them as refresh targets and starts the refresh counter. It sends no command. If no selected device is in self-refresh, `busy` lasts 1 cycle. Any other code leaves normal mode.
- R10: With `wr_sel`=1 the write loads the timing register: tMRD [3:0], tXSR [7:4], tRAS [11:8], tRC [15:12], tWR [19:16], tRP [23:20], tRCD [27:24].
- R11: With `wr_sel`=2 the write loads the refresh reload value R from bits [14:1]. R resets to 8196. The first automatic refresh pulse comes R+2 cycles after a normal command is accepted, and later ones follow every R+1 cycles. Each pulse goes to the recorded targets and keeps `busy` up for tRC+1 cycles.
- R12: A command word written while `busy` is high (including while a timer refresh is pending) is dropped and changes no pin.
- R13: `busy` rises at the edge that accepts a command. Chip select is never low while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 command, 1 timing, 2 refresh reload |
| wr_data | input | 32 | Register write value |
| busy | output | 1 | Command in progress or refresh pending |
| sd_cke | output | 2 | Clock enable per device |
| sd_cs_n | output | 2 | Chip select per device, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | Address pins |
| sd_ba | output | 2 | Bank address, held at 0 |

## Verification
A command is accepted at one clock edge, and its pin pattern and new `sd_cke` are due in the cycle right after that edge, which the bench calls cycle 0. `busy` is then due high for exactly the programmed delay, so it falls after delay cycles counted from cycle 0. Repeated refresh pulses are due at multiples of tRC+1 from cycle 0. A timer refresh is due R+2 cycles after the normal command is accepted. The bench drives and samples only on falling edges, takes the pins at cycle 0, and counts high cycles of `busy` and refresh pulses one falling edge at a time against these figures.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  localparam int TF_W         = 4;  // width of one recovery field
  localparam int CMD_OP_W     = 3;
  localparam int CMD_TGT_MSB  = 4;  // device 0 select; device g at bit 4-g
  localparam int CMD_NREF_LSB = 5;
  localparam int CMD_MODE_LSB = 9;

  localparam logic [1:0] SEL_CMD     = 2'd0;
  localparam logic [1:0] SEL_TIMING  = 2'd1;
  localparam logic [1:0] SEL_REFRESH = 2'd2;

  typedef enum logic [2:0] {
    OP_NORMAL = 3'd0,
    OP_CLKEN  = 3'd1,
    OP_PREALL = 3'd2,
    OP_AREF   = 3'd3,
    OP_LMR    = 3'd4,
    OP_SREF   = 3'd5,
    OP_PDOWN  = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  // field order follows the register layout (MSB first)
  typedef struct packed {
    logic [TF_W-1:0] t_rcd;
    logic [TF_W-1:0] t_rp;
    logic [TF_W-1:0] t_wr;
    logic [TF_W-1:0] t_rc;
    logic [TF_W-1:0] t_ras;
    logic [TF_W-1:0] t_xsr;
    logic [TF_W-1:0] t_mrd;
  } timing_t;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_cmd_t;

  localparam pin_cmd_t PC_NOP = pin_cmd_t'(3'b111);
  localparam pin_cmd_t PC_PRE = pin_cmd_t'(3'b010);
  localparam pin_cmd_t PC_REF = pin_cmd_t'(3'b001);
  localparam pin_cmd_t PC_MRS = pin_cmd_t'(3'b000);
endpackage

// File: rtl/sdseq_cfg_regs.sv
module sdseq_cfg_regs
  import sdseq_pkg::*;
#(
  parameter int N_DEV     = 2,
  parameter int NREF_W    = 4,
  parameter int MODE_W    = 13,
  parameter int RLD_W     = 14,
  parameter int RLD_RESET = 8196,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_wr,
  output op_e               cmd_op,
  output logic [N_DEV-1:0]  cmd_tgt,
  output logic [NREF_W-1:0] cmd_nref,
  output logic [MODE_W-1:0] cmd_mode,
  output timing_t           tim,
  output logic              rld_wr,
  output logic [RLD_W-1:0]  rld_new,
  output logic [RLD_W-1:0]  rld
);
  localparam int TIM_W = $bits(timing_t);
  localparam timing_t TIM_RESET = '1;

  // command word decode (R2, R5, R6)
  assign cmd_wr   = wr_en && (wr_sel == SEL_CMD);
  assign cmd_op   = op_e'(wr_data[CMD_OP_W-1:0]);
  assign cmd_nref = wr_data[CMD_NREF_LSB +: NREF_W];
  assign cmd_mode = wr_data[CMD_MODE_LSB +: MODE_W];

  generate
    for (genvar g = 0; g < N_DEV; g++) begin : g_tgt
      assign cmd_tgt[g] = wr_data[CMD_TGT_MSB-g];
    end
  endgenerate

  // refresh reload value sits from bit 1 upward (R11)
  assign rld_wr  = wr_en && (wr_sel == SEL_REFRESH);
  assign rld_new = wr_data[1 +: RLD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tim <= TIM_RESET;
      rld <= RLD_W'(RLD_RESET);
    end else begin
      if (wr_en && (wr_sel == SEL_TIMING)) tim <= timing_t'(wr_data[TIM_W-1:0]);  // R10
      if (rld_wr) rld <= rld_new;
    end
  end

  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:TIM_W];
endmodule

// File: rtl/sdseq_rfsh_timer.sv
module sdseq_rfsh_timer #(
  parameter int RLD_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             normal_mode,
  input  logic             restart,
  input  logic             rld_wr,
  input  logic [RLD_W-1:0] rld_new,
  input  logic [RLD_W-1:0] rld,
  input  logic             ack,
  output logic             pend
);
  logic [RLD_W-1:0] cnt_q;
  logic             fire;

  assign fire = normal_mode && !restart && !rld_wr && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else begin
      if (rld_wr)                         cnt_q <= rld_new;
      else if (restart || !normal_mode)   cnt_q <= rld;
      else if (cnt_q == '0)               cnt_q <= rld;
      else                                cnt_q <= cnt_q - 1'b1;
      pend <= normal_mode && (fire || (pend && !ack));
    end
  end

  AST_PEND_NEEDS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(normal_mode)); // R11
  AST_PEND_DROPS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !normal_mode |=> !pend); // R11
endmodule

// File: rtl/sdseq_cmd_engine.sv
module sdseq_cmd_engine
  import sdseq_pkg::*;
#(
  parameter int N_DEV  = 2,
  parameter int ADDR_W = 13,
  parameter int NREF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  op_e               cmd_op,
  input  logic [N_DEV-1:0]  cmd_tgt,
  input  logic [NREF_W-1:0] cmd_nref,
  input  logic [ADDR_W-1:0] cmd_mode,
  input  timing_t           tim,
  input  logic              rfsh_pend,
  output logic              rfsh_ack,
  output logic              restart,
  output logic              active,
  output logic              normal_mode,
  output logic [N_DEV-1:0]  cke,
  output logic [N_DEV-1:0]  cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);
  localparam int A10 = 10;

  logic              active_q, active_d;
  logic [TF_W-1:0]   wait_q, wait_d;
  logic [NREF_W-1:0] rep_q, rep_d;
  logic [N_DEV-1:0]  rep_tg_q, rep_tg_d;
  logic [N_DEV-1:0]  cke_q, cke_d;
  logic [N_DEV-1:0]  sr_q, sr_d;
  logic              norm_q, norm_d;
  logic [N_DEV-1:0]  norm_tg_q, norm_tg_d;
  pin_cmd_t          pc_q, pc_d;
  logic [N_DEV-1:0]  sel_d;
  logic [N_DEV-1:0]  cs_n_q;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    active_d  = active_q;
    wait_d    = wait_q;
    rep_d     = rep_q;
    rep_tg_d  = rep_tg_q;
    cke_d     = cke_q;
    sr_d      = sr_q;
    norm_d    = norm_q;
    norm_tg_d = norm_tg_q;
    pc_d      = PC_NOP;
    sel_d     = '0;
    addr_d    = '0;
    rfsh_ack  = 1'b0;
    restart   = 1'b0;
    if (active_q) begin
      // recovery countdown, then further refresh pulses if any remain
      if (wait_q != '0) begin
        wait_d = wait_q - 1'b1;
      end else if (rep_q != '0) begin
        rep_d  = rep_q - 1'b1;
        pc_d   = PC_REF;
        sel_d  = rep_tg_q;
        wait_d = tim.t_rc;
      end else begin
        active_d = 1'b0;
      end
    end else if (rfsh_pend) begin
      // timer refresh wins over a software write in the same cycle
      rfsh_ack = 1'b1;
      active_d = 1'b1;
      pc_d     = PC_REF;
      sel_d    = norm_tg_q;
      wait_d   = tim.t_rc;
      rep_d    = '0;
    end else if (cmd_wr) begin
      active_d = 1'b1;
      wait_d   = '0;
      rep_d    = '0;
      norm_d   = (cmd_op == OP_NORMAL);
      case (cmd_op)
        OP_NORMAL: begin
          cke_d     = cke_q | cmd_tgt;
          sr_d      = sr_q & ~cmd_tgt;
          norm_tg_d = cmd_tgt;
          restart   = 1'b1;
          if (|(sr_q & cmd_tgt)) wait_d = tim.t_xsr;
        end
        OP_CLKEN: cke_d = cke_q | cmd_tgt;
        OP_PREALL: begin
          pc_d        = PC_PRE;
          sel_d       = cmd_tgt;
          addr_d[A10] = 1'b1;
          wait_d      = tim.t_rp;
        end
        OP_AREF: begin
          pc_d     = PC_REF;
          sel_d    = cmd_tgt;
          wait_d   = tim.t_rc;
          rep_d    = cmd_nref;
          rep_tg_d = cmd_tgt;
        end
        OP_LMR: begin
          pc_d   = PC_MRS;
          sel_d  = cmd_tgt;
          addr_d = cmd_mode;
          wait_d = tim.t_mrd;
        end
        OP_SREF: begin
          pc_d   = PC_REF;
          sel_d  = cmd_tgt;
          cke_d  = cke_q & ~cmd_tgt;
          sr_d   = sr_q | cmd_tgt;
          wait_d = tim.t_ras;
        end
        OP_PDOWN: cke_d = cke_q & ~cmd_tgt;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      wait_q    <= '0;
      rep_q     <= '0;
      rep_tg_q  <= '0;
      cke_q     <= '0;
      sr_q      <= '0;
      norm_q    <= 1'b0;
      norm_tg_q <= '0;
      pc_q      <= PC_NOP;
      cs_n_q    <= '1;
      addr_q    <= '0;
    end else begin
      active_q  <= active_d;
      wait_q    <= wait_d;
      rep_q     <= rep_d;
      rep_tg_q  <= rep_tg_d;
      cke_q     <= cke_d;
      sr_q      <= sr_d;
      norm_q    <= norm_d;
      norm_tg_q <= norm_tg_d;
      pc_q      <= pc_d;
      cs_n_q    <= ~sel_d;
      addr_q    <= addr_d;
    end
  end

  assign active      = active_q;
  assign normal_mode = norm_q;
  assign cke         = cke_q;
  assign cs_n        = cs_n_q;
  assign ras_n       = pc_q.ras_n;
  assign cas_n       = pc_q.cas_n;
  assign we_n        = pc_q.we_n;
  assign addr        = addr_q;

  logic unused_tim;
  assign unused_tim = ^{tim.t_wr, tim.t_rcd};

  AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (&cs_n_q)); // R13
  AST_CKE_AT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cke_q) |-> $rose(active_q)); // R3
  AST_PREALL_A10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pc_q == PC_PRE) && !(&cs_n_q)) |-> addr_q[A10]); // R4
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cmd_wr) |=> ($stable(cke_q) && $stable(norm_q))); // R12
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdseq_pkg::*;
#(
  parameter int N_DEV     = 2,
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int NREF_W    = 4,
  parameter int RLD_W     = 14,
  parameter int RLD_RESET = 8196,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic [N_DEV-1:0]  sd_cke,
  output logic [N_DEV-1:0]  sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba
);
  logic              cmd_wr;
  op_e               cmd_op;
  logic [N_DEV-1:0]  cmd_tgt;
  logic [NREF_W-1:0] cmd_nref;
  logic [ADDR_W-1:0] cmd_mode;
  timing_t           tim;
  logic              rld_wr;
  logic [RLD_W-1:0]  rld_new, rld;
  logic              pend, ack, restart, active, normal_mode;

  sdseq_cfg_regs #(
    .N_DEV(N_DEV), .NREF_W(NREF_W), .MODE_W(ADDR_W),
    .RLD_W(RLD_W), .RLD_RESET(RLD_RESET), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_tgt(cmd_tgt), .cmd_nref(cmd_nref),
    .cmd_mode(cmd_mode), .tim(tim), .rld_wr(rld_wr), .rld_new(rld_new), .rld(rld)
  );

  sdseq_rfsh_timer #(.RLD_W(RLD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .normal_mode(normal_mode), .restart(restart),
    .rld_wr(rld_wr), .rld_new(rld_new), .rld(rld), .ack(ack), .pend(pend)
  );

  sdseq_cmd_engine #(.N_DEV(N_DEV), .ADDR_W(ADDR_W), .NREF_W(NREF_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_tgt(cmd_tgt),
    .cmd_nref(cmd_nref), .cmd_mode(cmd_mode), .tim(tim), .rfsh_pend(pend),
    .rfsh_ack(ack), .restart(restart), .active(active), .normal_mode(normal_mode),
    .cke(sd_cke), .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n),
    .we_n(sd_we_n), .addr(sd_addr)
  );

  assign busy  = active | pend;
  assign sd_ba = '0;

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr) |=> busy); // R13
endmodule

// File: tb/sdram_cmd_seq_bench.sv
module sdram_cmd_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        busy;
  logic [1:0]  cke, cs_n, ba;
  logic        ras_n, cas_n, we_n;
  logic [12:0] addr;

  always #2 clk = ~clk;

  sdram_cmd_seq u_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .sd_cke(cke), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n),
    .sd_we_n(we_n), .sd_addr(addr), .sd_ba(ba)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R13 watchdog: actual %0d cycles expected fewer", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic ref_on();
    return !ras_n && !cas_n && we_n && !(&cs_n);
  endfunction

  // all tasks start and end on a falling edge
  task automatic put(logic [1:0] sel, logic [31:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue(logic [1:0] sel, logic [31:0] d);
    while (busy) @(negedge clk);
    put(sel, d);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'd0: return "R9";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd6: return "R8";
      default: return "R2";
    endcase
  endfunction

  typedef struct packed {
    logic [31:0] word;
    logic [2:0]  rcw;
    logic [1:0]  csn;
    logic [1:0]  cke;
    logic [12:0] addr;
    logic [7:0]  blen;
  } vec_t;

  // timing: tRCD0 tRP1 tWR0 tRC2 tRAS3 tXSR5 tMRD1
  localparam logic [31:0] TIMING = 32'h0010_2351;

  localparam vec_t VEC [8] = '{
    '{32'h0000_0019, 3'b111, 2'b11, 2'b11, 13'h000, 8'd1},  // clock enable both
    '{32'h0000_0012, 3'b010, 2'b10, 2'b11, 13'h400, 8'd2},  // precharge dev0
    '{32'h0000_600C, 3'b000, 2'b01, 2'b11, 13'h030, 8'd2},  // mode load dev1, CL3 BL1
    '{32'h0000_001B, 3'b001, 2'b00, 2'b11, 13'h000, 8'd3},  // one refresh both
    '{32'h0000_000E, 3'b111, 2'b11, 2'b01, 13'h000, 8'd1},  // power-down dev1
    '{32'h0000_0008, 3'b111, 2'b11, 2'b11, 13'h000, 8'd1},  // normal dev1
    '{32'h0000_0011, 3'b111, 2'b11, 2'b11, 13'h000, 8'd1},  // clock enable dev0
    '{32'h0000_0002, 3'b010, 2'b11, 2'b11, 13'h400, 8'd2}   // precharge, no device
  };

  initial begin
    int n, p, last, t0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", {31'd0, busy}, 32'd0);
    chk("R1", "cke in reset", {30'd0, cke}, 32'd0);
    chk("R1", "cs_n in reset", {30'd0, cs_n}, 32'd3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pins after reset", {29'd0, ras_n, cas_n, we_n}, 32'd7);
    chk("R1", "addr after reset", {19'd0, addr}, 32'd0);
    chk("R1", "busy after reset", {31'd0, busy}, 32'd0);

    issue(2'd1, TIMING);  // R10

    // table walk: pins at cycle 0 and busy length
    for (int i = 0; i < 8; i++) begin
      string tg;
      tg = op_tag(VEC[i].word[2:0]);
      issue(2'd0, VEC[i].word);
      chk(tg, "ras/cas/we", {29'd0, ras_n, cas_n, we_n}, {29'd0, VEC[i].rcw});
      chk(tg, "cs_n (R2)", {30'd0, cs_n}, {30'd0, VEC[i].csn});
      chk(tg, "cke", {30'd0, cke}, {30'd0, VEC[i].cke});
      chk(tg, "addr", {19'd0, addr}, {19'd0, VEC[i].addr});
      busy_len(n);
      chk(tg, "busy length (R10)", n, {24'd0, VEC[i].blen});
      chk(tg, "cs_n after command", {30'd0, cs_n}, 32'd3);
    end

    // R5: four refreshes, spacing tRC+1 = 3
    issue(2'd0, 32'h0000_007B);
    n = 0; p = 0; last = -1;
    while (busy) begin
      if (ref_on()) begin p++; last = n; end
      n++;
      @(negedge clk);
    end
    chk("R5", "refresh pulses", p, 32'd4);
    chk("R5", "last pulse cycle", last, 32'd9);
    chk("R5", "busy length", n, 32'd12);

    // R12: power-down written while precharge busy is dropped
    issue(2'd0, 32'h0000_0012);
    put(2'd0, 32'h0000_001E);
    busy_len(n);
    chk("R12", "remaining busy", n, 32'd1);
    chk("R12", "cke unchanged", {30'd0, cke}, 32'd3);
    chk("R12", "no pin command", {30'd0, cs_n}, 32'd3);

    // R7: self-refresh dev0 then normal exit
    issue(2'd0, 32'h0000_0015);
    chk("R7", "self-refresh pins", {29'd0, ras_n, cas_n, we_n}, 32'd1);
    chk("R7", "self-refresh cs_n", {30'd0, cs_n}, 32'd2);
    chk("R7", "self-refresh cke", {30'd0, cke}, 32'd2);
    busy_len(n);
    chk("R7", "self-refresh busy", n, 32'd4);
    issue(2'd0, 32'h0000_0010);
    t0 = cyc;
    chk("R7", "exit cke", {30'd0, cke}, 32'd3);
    busy_len(n);
    chk("R7", "exit busy tXSR+1", n, 32'd6);

    // R11: default reload 8196 -> first refresh 8198 cycles after accept
    while (!ref_on()) @(negedge clk);
    chk("R11", "default refresh delay", cyc - t0, 32'd8198);
    chk("R11", "refresh target dev0", {30'd0, cs_n}, 32'd2);
    busy_len(n);
    chk("R11", "timer refresh busy", n, 32'd3);

    // R11: programmed reload 20, targets dev1
    issue(2'd2, 32'd40);
    issue(2'd0, 32'h0000_0008);
    t0 = cyc;
    while (!ref_on()) @(negedge clk);
    chk("R11", "programmed first refresh", cyc - t0, 32'd22);
    chk("R11", "refresh target dev1", {30'd0, cs_n}, 32'd1);
    @(negedge clk);
    while (!ref_on()) @(negedge clk);
    chk("R11", "refresh period", cyc - t0, 32'd43);
    chk("R13", "busy during timer refresh", {31'd0, busy}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule